// File: doc/BRIEF.md
# DRAM Compressed Parallel-Test Controller

This block models the strobe decoding and data path of a small dynamic memory array. Inside, the array holds eight-bit words. Outside, the data bus is four lines wide. Active-low row strobe (`ras_n`), column strobe (`cas_n`) and write enable (`we_n`) are sampled on the system clock. The row address is captured when the row strobe falls, and the column address when the column strobe falls, both from one multiplexed address bus. In normal mode, column address bit 0 picks which nibble of the internal word an access uses.

A cycle with write enable and column strobe both low before the row strobe falls puts the block into a compressed test mode. In that mode a write copies data line 1 into all eight bits of the addressed word. A read reports on data line 4 whether the eight bits agree, and drives lines 1 to 3 high. The block returns to normal mode on any of three cycles: a column-before-row refresh with write enable high, a row-only refresh, or a hidden refresh.

The uppermost address bit of both the row and the column is not decoded by the array. Column bit 0 is ignored in test mode.

Top module: `dram_ptest_ctrl`

## Requirements
- R1: While `rst` is high, and after it is released, the block is in normal mode with `dq_oe` low and `dq_out` zero.
- R2: A normal write stores `dq_in` into the nibble picked by column bit 0 (0 = internal bits 3:0, 1 = bits 7:4) of word {row bits, column bits [COL_BITS:1]}. The other nibble is unchanged. A normal read returns that nibble on `dq_out`.
- R3: Address and data are captured at the strobe edges. Changing `addr` or `dq_in` after the column strobe has been sampled low has no effect on the access.
- R4: A read drives `dq_oe` high on the fourth rising edge, counting the first edge that samples `cas_n` low as the first. `dq_oe` stays high until the second rising edge that samples `cas_n` high.
- R5: A falling row strobe sampled with `cas_n` and `we_n` both low sets test mode. Repeating this cycle while already in test mode keeps test mode.
- R6: In test mode, a write sets all eight bits of the addressed word to `dq_in[0]`. `dq_in[3:1]` are ignored.
- R7: In test mode, a read drives `dq_out` = {E,1,1,1}, where E (line 4, bit 3) is 1 exactly when all eight bits of the word are equal.
- R8: The top row bit and the top column bit (`addr[ADDR_W-1]`) are never decoded. In test mode column bit 0 is also ignored.
- R9: A falling row strobe sampled with `cas_n` low and `we_n` high clears test mode.
- R10: A row strobe that falls with `cas_n` high and rises with no column strobe in between clears test mode.
- R11: A hidden refresh clears test mode. This is a read whose `cas_n` stays low while the row strobe rises and falls again.
- R12: Write cycles never raise `dq_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low, sampled with the column strobe |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 4 | Write data lines (bit 0 = line 1) |
| dq_out | output | 4 | Registered read data (bit 3 = line 4) |
| dq_oe | output | 1 | Output enable for the read data |

## Verification
The bound checker watches the mode flag on every cycle. It checks that the flag only rises two edges after a sampled row-strobe fall, and only falls two edges after a row-strobe transition. It checks that WCBR and CBR cycles move the flag the right way, that reset clears the flag and the output enable, and that a long-idle column strobe leaves the bus released. Only the bench's scenarios can show what the stored data and its readback are: nibble placement, broadcast writes, the equality flag, address bits being ignored, the hidden-refresh exit, and the exact edge on which read data becomes valid.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

  localparam int DQ_W   = 4;
  localparam int WORD_W = 8;
  localparam int HALVES = WORD_W / DQ_W;

  // classification of a sampled row-strobe fall
  typedef enum logic [1:0] {
    RK_NONE,
    RK_ROW,
    RK_CBR,
    RK_WCBR
  } ras_kind_e;

  // one column access, valid for a single cycle
  typedef struct packed {
    logic            go;
    logic            wr;
    logic            tst;
    logic            half;
    logic [DQ_W-1:0] dat;
  } acc_t;

endpackage

// File: rtl/dpt_strobe_decode.sv
module dpt_strobe_decode
  import dpt_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int ADDR_W   = 4,
  parameter int IDX_W    = ROW_BITS + COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic              test_mode,
  output logic              cas_idle,
  output acc_t              acc,
  output logic [IDX_W-1:0]  acc_idx
);

  // input sampling stage
  logic              ras_q, ras_qq, cas_q, cas_qq, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   dq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_q  <= 1'b1;
      ras_qq <= 1'b1;
      cas_q  <= 1'b1;
      cas_qq <= 1'b1;
      we_q   <= 1'b1;
      addr_q <= '0;
      dq_q   <= '0;
    end else begin
      ras_q  <= ras_n;
      ras_qq <= ras_q;
      cas_q  <= cas_n;
      cas_qq <= cas_q;
      we_q   <= we_n;
      addr_q <= addr;
      dq_q   <= dq_in;
    end
  end

  logic ras_fall, ras_rise, cas_fall;
  assign ras_fall = ras_qq & ~ras_q;
  assign ras_rise = ~ras_qq & ras_q;
  assign cas_fall = cas_qq & ~cas_q;
  assign cas_idle = cas_q;

  // the top address bit is never decoded by the array
  logic unused_top_bit;
  assign unused_top_bit = addr_q[ADDR_W-1];

  ras_kind_e kind;
  always_comb begin
    kind = RK_NONE;
    if (ras_fall) begin
      if (cas_q)      kind = RK_ROW;
      else if (we_q)  kind = RK_CBR;
      else            kind = RK_WCBR;
    end
  end

  logic                row_cycle, cas_seen;
  logic [ROW_BITS-1:0] row_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      test_mode <= 1'b0;
      row_cycle <= 1'b0;
      cas_seen  <= 1'b0;
      row_lat   <= '0;
      acc       <= '0;
      acc_idx   <= '0;
    end else begin
      acc.go <= 1'b0;
      unique case (kind)
        RK_WCBR: test_mode <= 1'b1;
        RK_CBR:  test_mode <= 1'b0;
        RK_ROW: begin
          row_cycle <= 1'b1;
          cas_seen  <= 1'b0;
          row_lat   <= addr_q[ROW_BITS-1:0];
        end
        default: ;
      endcase
      if (ras_rise) begin
        if (row_cycle && !cas_seen) test_mode <= 1'b0;
        row_cycle <= 1'b0;
      end
      if (cas_fall && !ras_q && row_cycle) begin
        cas_seen <= 1'b1;
        acc.go   <= 1'b1;
        acc.wr   <= ~we_q;
        acc.tst  <= test_mode;
        acc.half <= addr_q[0];
        acc.dat  <= dq_q;
        acc_idx  <= {row_lat, addr_q[COL_BITS:1]};
      end
    end
  end

endmodule

// File: rtl/dpt_nibble_bank.sv
module dpt_nibble_bank #(
  parameter int IDX_W = 4,
  parameter int DAT_W = 4,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             wen,
  input  logic [IDX_W-1:0] idx,
  input  logic [DAT_W-1:0] wdata,
  output logic [DAT_W-1:0] rdata
);

  logic [DAT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wen) mem[idx] <= wdata;
    rdata <= mem[idx];
  end

endmodule

// File: rtl/dpt_read_format.sv
module dpt_read_format
  import dpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_go,
  input  logic              rd_tst,
  input  logic              rd_half,
  input  logic              cas_idle,
  input  logic [WORD_W-1:0] word,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe
);

  logic pend, pend_tst, pend_half;
  logic all_eq;

  assign all_eq = (&word) | ~(|word);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_tst  <= 1'b0;
      pend_half <= 1'b0;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
    end else begin
      pend <= rd_go;
      if (rd_go) begin
        pend_tst  <= rd_tst;
        pend_half <= rd_half;
      end
      if (cas_idle) begin
        dq_oe <= 1'b0;
      end else if (pend) begin
        dq_oe <= 1'b1;
        if (pend_tst)       dq_out <= {all_eq, {(DQ_W-1){1'b1}}};
        else if (pend_half) dq_out <= word[WORD_W-1 -: DQ_W];
        else                dq_out <= word[DQ_W-1:0];
      end
    end
  end

endmodule

// File: rtl/dram_ptest_ctrl.sv
module dram_ptest_ctrl
  import dpt_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int ADDR_W   = ((ROW_BITS > COL_BITS + 1) ? ROW_BITS : COL_BITS + 1) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        dq_in,
  output logic [3:0]        dq_out,
  output logic              dq_oe
);

  localparam int IDX_W = ROW_BITS + COL_BITS;

  logic             test_mode;
  logic             cas_idle;
  acc_t             acc;
  logic [IDX_W-1:0] acc_idx;

  dpt_strobe_decode #(
    .ROW_BITS(ROW_BITS),
    .COL_BITS(COL_BITS),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W)
  ) u_dec (
    .clk      (clk),
    .rst      (rst),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .addr     (addr),
    .dq_in    (dq_in),
    .test_mode(test_mode),
    .cas_idle (cas_idle),
    .acc      (acc),
    .acc_idx  (acc_idx)
  );

  // broadcast line 1 in test mode, otherwise pass the nibble through
  logic [DQ_W-1:0]   wdata;
  logic [WORD_W-1:0] word;

  assign wdata = acc.tst ? {DQ_W{acc.dat[0]}} : acc.dat;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic wen;
    assign wen = acc.go & acc.wr & (acc.tst | (acc.half == h[0]));
    dpt_nibble_bank #(
      .IDX_W(IDX_W),
      .DAT_W(DQ_W)
    ) u_bank (
      .clk  (clk),
      .wen  (wen),
      .idx  (acc_idx),
      .wdata(wdata),
      .rdata(word[h*DQ_W +: DQ_W])
    );
  end

  dpt_read_format u_fmt (
    .clk     (clk),
    .rst     (rst),
    .rd_go   (acc.go & ~acc.wr),
    .rd_tst  (acc.tst),
    .rd_half (acc.half),
    .cas_idle(cas_idle),
    .word    (word),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe)
  );

endmodule

// File: rtl/dpt_checker.sv
module dpt_checker (
  input logic clk,
  input logic rst,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic test_mode,
  input logic dq_oe
);

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!test_mode && !dq_oe));

  // R5
  a_r5_wcbr_enters: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && !cas_n && !we_n) |-> ##2 test_mode);

  // R5: entry only follows a sampled row-strobe fall
  a_r5_entry_source: assert property (@(posedge clk) disable iff (rst)
    $rose(test_mode) |-> (!$past(ras_n, 2) && $past(ras_n, 3)));

  // R9
  a_r9_cbr_exits: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && !cas_n && we_n) |-> ##2 !test_mode);

  // R10, R11: exit only follows a row-strobe transition
  a_r10_exit_source: assert property (@(posedge clk) disable iff (rst)
    $fell(test_mode) |-> ($past(ras_n, 2) != $past(ras_n, 3)));

  // R4
  a_r4_bus_released: assert property (@(posedge clk) disable iff (rst)
    ($past(cas_n, 2) && $past(cas_n) && cas_n) |-> !dq_oe);

endmodule

bind dram_ptest_ctrl dpt_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .we_n     (we_n),
  .test_mode(test_mode),
  .dq_oe    (dq_oe)
);

// File: tb/dram_ptest_ctrl_test.sv
module dram_ptest_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int NVEC       = 23;

  // vector: {op[2:0], row[3:0], col[3:0], dat[3:0], exp[3:0]}
  // op: 0 write, 1 read, 2 WCBR, 3 CBR refresh, 4 row-only refresh
  localparam logic [18:0] VEC [NVEC] = '{
    {3'd0, 4'h0, 4'h0, 4'hA, 4'h0},  // R2 low nibble
    {3'd0, 4'h0, 4'h1, 4'h5, 4'h0},  // R2 high nibble
    {3'd1, 4'h0, 4'h0, 4'h0, 4'hA},  // R2
    {3'd1, 4'h0, 4'h1, 4'h0, 4'h5},  // R2
    {3'd0, 4'h1, 4'h2, 4'h3, 4'h0},
    {3'd1, 4'h9, 4'h2, 4'h0, 4'h3},  // R8 top row bit
    {3'd1, 4'h1, 4'hA, 4'h0, 4'h3},  // R8 top col bit
    {3'd2, 4'h0, 4'h0, 4'h0, 4'h0},  // R5 enter
    {3'd1, 4'h0, 4'h0, 4'h0, 4'h7},  // R7 mismatch
    {3'd0, 4'h0, 4'h0, 4'hE, 4'h0},  // R6 line1=0, others ignored
    {3'd1, 4'h0, 4'h1, 4'h0, 4'hF},  // R7 all zeros
    {3'd0, 4'h8, 4'h9, 4'h1, 4'h0},  // R8 don't-care bits
    {3'd1, 4'h0, 4'h0, 4'h0, 4'hF},  // R7 all ones
    {3'd2, 4'h0, 4'h0, 4'h0, 4'h0},  // R5 repeat keeps mode
    {3'd0, 4'h1, 4'h2, 4'h0, 4'h0},  // R6 broadcast zero
    {3'd3, 4'h0, 4'h0, 4'h0, 4'h0},  // R9 exit
    {3'd1, 4'h1, 4'h2, 4'h0, 4'h0},  // R9 normal read
    {3'd1, 4'h1, 4'h3, 4'h0, 4'h0},  // R6 both halves written
    {3'd1, 4'h0, 4'h1, 4'h0, 4'hF},
    {3'd2, 4'h0, 4'h0, 4'h0, 4'h0},
    {3'd4, 4'h2, 4'h0, 4'h0, 4'h0},  // R10 exit
    {3'd0, 4'h2, 4'h0, 4'h6, 4'h0},
    {3'd1, 4'h2, 4'h0, 4'h0, 4'h6}   // R10 normal write kept nibble
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ras_n = 1'b1;
  logic       cas_n = 1'b1;
  logic       we_n = 1'b1;
  logic [3:0] addr = '0;
  logic [3:0] dq_in = '0;
  logic [3:0] dq_out;
  logic       dq_oe;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  logic [7:0] ref_mem [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_ptest_ctrl uut (
    .clk   (clk),
    .rst   (rst),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .addr  (addr),
    .dq_in (dq_in),
    .dq_out(dq_out),
    .dq_oe (dq_oe)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ras_down(input logic [3:0] row);
    @(negedge clk);
    addr  = row;
    ras_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_write(input logic [3:0] row, input logic [3:0] col, input logic [3:0] d);
    ras_down(row);
    addr  = col;
    dq_in = d;
    we_n  = 1'b0;
    cas_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R12", {3'b0, dq_oe}, 4'h0);
    cas_n = 1'b1;
    ras_n = 1'b1;
    we_n  = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // read with full R4 timing checks; keep_cas leaves CAS low for a hidden refresh
  task automatic do_read(input logic [3:0] row, input logic [3:0] col,
                         input bit keep_cas, output logic [3:0] val);
    ras_down(row);
    addr  = col;
    cas_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 early", {3'b0, dq_oe}, 4'h0);
    @(negedge clk);
    chk("R4 valid", {3'b0, dq_oe}, 4'h1);
    val = dq_out;
    addr = 4'hF;  // R3 late address change
    if (!keep_cas) begin
      cas_n = 1'b1;
      @(negedge clk);
      chk("R4 hold", {3'b0, dq_oe}, 4'h1);
      @(negedge clk);
      chk("R4 release", {3'b0, dq_oe}, 4'h0);
      ras_n = 1'b1;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic refresh(input bit with_we);
    @(negedge clk);
    cas_n = 1'b0;
    we_n  = with_we ? 1'b0 : 1'b1;
    repeat (2) @(negedge clk);
    ras_n = 1'b0;
    repeat (3) @(negedge clk);
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic ras_only(input logic [3:0] row);
    ras_down(row);
    repeat (2) @(negedge clk);
    ras_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] v;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", {3'b0, dq_oe}, 4'h0);
    chk("R1 out in reset", dq_out, 4'h0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 oe after reset", {3'b0, dq_oe}, 4'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] op;
      logic [3:0] row, col, dat, exp;
      {op, row, col, dat, exp} = VEC[i];
      case (op)
        3'd0: do_write(row, col, dat);
        3'd1: begin
          do_read(row, col, 1'b0, v);
          chk($sformatf("R2/R7 vector %0d", i), v, exp);
        end
        3'd2: refresh(1'b1);
        3'd3: refresh(1'b0);
        default: ras_only(row);
      endcase
    end

    // R3: address and data change after CAS is sampled
    ras_down(4'h2);
    addr = 4'h1; dq_in = 4'h9; we_n = 1'b0; cas_n = 1'b0;
    repeat (2) @(negedge clk);
    addr = 4'hF; dq_in = 4'h0;
    repeat (2) @(negedge clk);
    cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
    do_read(4'h2, 4'h1, 1'b0, v);
    chk("R3 late change ignored", v, 4'h9);

    // R11: hidden refresh after a test-mode read
    refresh(1'b1);
    do_read(4'h0, 4'h0, 1'b1, v);
    chk("R7 before hidden refresh", v, 4'hF);
    ras_n = 1'b1;
    repeat (2) @(negedge clk);
    ras_n = 1'b0;
    repeat (3) @(negedge clk);
    ras_n = 1'b1; cas_n = 1'b1;
    repeat (3) @(negedge clk);
    do_read(4'h1, 4'h2, 1'b0, v);
    chk("R11 normal after hidden refresh", v, 4'h0);

    // full sweep: normal nibble writes against reference model
    for (int w = 0; w < 16; w++) begin
      logic [3:0] lo, hi;
      lo = 4'((w * 7 + 1) & 15);
      hi = 4'((w * 3 + 2) & 15);
      ref_mem[w] = {hi, lo};
      do_write(4'(w >> 2), 4'((w & 3) << 1), lo);
      do_write(4'(w >> 2), 4'(((w & 3) << 1) | 1), hi);
    end
    for (int w = 0; w < 16; w++) begin
      do_read(4'(w >> 2), 4'((w & 3) << 1), 1'b0, v);
      chk("R2 sweep low", v, ref_mem[w][3:0]);
      do_read(4'(w >> 2), 4'(((w & 3) << 1) | 1), 1'b0, v);
      chk("R2 sweep high", v, ref_mem[w][7:4]);
    end
    // test-mode compare of mixed words: expect mismatch unless all equal
    refresh(1'b1);
    for (int w = 0; w < 16; w++) begin
      logic e;
      e = (ref_mem[w] == 8'h00) || (ref_mem[w] == 8'hFF);
      do_read(4'(w >> 2), 4'((w & 3) << 1), 1'b0, v);
      chk("R7 sweep compare", v, {e, 3'b111});
    end
    // broadcast writes, lines 2-4 set opposite to line 1
    for (int w = 0; w < 16; w++) begin
      logic b;
      b = w[0];
      ref_mem[w] = {8{b}};
      do_write(4'(w >> 2), 4'((w & 3) << 1), {{3{~b}}, b});
    end
    for (int w = 0; w < 16; w++) begin
      do_read(4'(w >> 2), 4'(((w & 3) << 1) | 1), 1'b0, v);
      chk("R7 sweep equal", v, 4'hF);
    end
    ras_only(4'h0);
    for (int w = 0; w < 16; w++) begin
      do_read(4'(w >> 2), 4'(((w & 3) << 1) | 1), 1'b0, v);
      chk("R6 sweep broadcast", v, ref_mem[w][7:4]);
    end

    // R1: reset mid-run returns to normal mode
    refresh(1'b1);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    do_write(4'h3, 4'h6, 4'hC);
    do_read(4'h3, 4'h6, 1'b0, v);
    chk("R1 normal mode after reset", v, 4'hC);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule